// File: doc/BRIEF.md
# Reverse Translation Synonym Filter

This block is a physical-to-virtual lookup table that sits beside a first-level TLB and is kept in step with it. It has one slot per TLB entry, and each slot is addressed by the TLB entry number. Before the TLB installs any translation, the insert is offered here. The table compares the physical page against every live slot in parallel. If a live slot already maps that physical page under another virtual page or address space, the insert is turned into a re-tag of that slot, so the TLB keeps the entry's per-line presence and way state. If no slot maps the page, the translation is written into the victim slot that the TLB picked, and the TLB allocates a fresh entry there.

The answer is registered and offered through a valid/ready handshake. The TLB reports evictions on a separate input, which is accepted in every cycle. An eviction in the same cycle as a lookup is applied before the lookup. The controller has two states. In IDLE it accepts a request (transition ACCEPT, to HOLD). In HOLD it presents the response until the consumer takes it (transition RELEASE, back to IDLE), and it stays in HOLD while the response is not taken (transition STALL).

Top module: `synonym_filter`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, and every slot is empty, so the first insert of any physical page is answered with allocate.
- R2: An insert whose physical page matches no live slot is answered with `rsp_kind` = 0 (allocate) and `rsp_idx` = `req_slot`. The slot then holds the new translation, and any previous occupant of that slot is replaced.
- R3: An insert whose physical page matches a live slot holding a different virtual page is answered with `rsp_kind` = 1 (rewrite) and `rsp_idx` = that slot, not `req_slot`. The slot's virtual page and ASID are overwritten, and its physical page is kept.
- R4: An insert that matches a live slot on physical and virtual page, and differs only in ASID, is answered with rewrite, and the slot's ASID is replaced.
- R5: An insert identical to a live slot in all three fields is answered with `rsp_kind` = 2 (present) at that slot, and the table is unchanged.
- R6: `evict_valid` with `evict_idx` empties that slot, so a later insert of its physical page allocates.
- R7: An eviction in the same cycle as an accepted insert takes effect before the lookup of that insert.
- R8: A request is accepted when `req_valid` and `req_ready` are both 1 at a rising edge. The response appears with `rsp_valid` = 1 after that edge and holds its fields stable until `rsp_ready` is 1. `req_ready` is 0 while a response is pending, and a request offered during that time has no effect.
- R9: Evictions are applied in both states, including while a response waits for `rsp_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Insert request present |
| req_ready | output | 1 | Table can accept an insert |
| req_vpn | input | VPN_W | Virtual page of the insert |
| req_asid | input | ASID_W | Address space of the insert |
| req_ppn | input | PPN_W | Physical page of the insert |
| req_slot | input | IDX_W | TLB victim slot used if the insert allocates |
| evict_valid | input | 1 | TLB evicted an entry |
| evict_idx | input | IDX_W | Slot of the evicted entry |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_kind | output | 2 | 0 allocate, 1 rewrite, 2 present |
| rsp_idx | output | IDX_W | Slot the TLB must use |

## Verification
The bench builds the table with four slots, 8-bit virtual pages, 4-bit ASIDs and 6-bit physical pages. With only four slots, every slot is reused and overwritten within a few inserts. A narrow random range of pages makes physical matches, virtual-page collisions and evictions of the matching slot frequent. These widths bring same-cycle eviction of the matched slot, allocation over a live victim, and eviction during a stalled response within reach of both the directed sequence and the random phase.

// File: rtl/synfilt_pkg.sv
package synfilt_pkg;
    typedef enum logic [1:0] {
        RES_ALLOC   = 2'd0,
        RES_REWRITE = 2'd1,
        RES_PRESENT = 2'd2
    } res_kind_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/synfilt_table.sv
module synfilt_table #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PPN_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              evict_valid,
    input  logic [IDX_W-1:0]                  evict_idx,
    input  logic                              wr_en,
    input  logic                              wr_full,
    input  logic [IDX_W-1:0]                  wr_idx,
    input  logic [VPN_W-1:0]                  wr_vpn,
    input  logic [ASID_W-1:0]                 wr_asid,
    input  logic [PPN_W-1:0]                  wr_ppn,
    output logic [ENTRIES-1:0]                live_vec,
    output logic [ENTRIES-1:0][VPN_W-1:0]     vpn_tab,
    output logic [ENTRIES-1:0][ASID_W-1:0]    asid_tab,
    output logic [ENTRIES-1:0][PPN_W-1:0]     ppn_tab
);
    logic [ENTRIES-1:0]             valid_q;
    logic [ENTRIES-1:0]             kill_vec;
    logic [ENTRIES-1:0]             set_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_q;

    // Eviction is folded in before anything reads the table.
    always_comb begin
        kill_vec = '0;
        set_vec  = '0;
        if (evict_valid) kill_vec[evict_idx] = 1'b1;
        if (wr_en)       set_vec[wr_idx]     = 1'b1;
        live_vec = valid_q & ~kill_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            vpn_q   <= '0;
            asid_q  <= '0;
            ppn_q   <= '0;
        end else begin
            valid_q <= live_vec | set_vec;
            if (wr_en) begin
                vpn_q[wr_idx]  <= wr_vpn;
                asid_q[wr_idx] <= wr_asid;
                if (wr_full) ppn_q[wr_idx] <= wr_ppn;
            end
        end
    end

    assign vpn_tab  = vpn_q;
    assign asid_tab = asid_q;
    assign ppn_tab  = ppn_q;

    AST_EVICT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid && !(wr_en && wr_idx == evict_idx) |=> !valid_q[$past(evict_idx)]); // R6
    AST_WRITE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid_q[$past(wr_idx)]); // R2
    AST_PPN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_full |=> ppn_q[$past(wr_idx)] == $past(ppn_q[wr_idx])); // R3
endmodule

// File: rtl/synfilt_match.sv
module synfilt_match #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PPN_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [ENTRIES-1:0]                live_vec,
    input  logic [ENTRIES-1:0][VPN_W-1:0]     vpn_tab,
    input  logic [ENTRIES-1:0][ASID_W-1:0]    asid_tab,
    input  logic [ENTRIES-1:0][PPN_W-1:0]     ppn_tab,
    input  logic [VPN_W-1:0]                  req_vpn,
    input  logic [ASID_W-1:0]                 req_asid,
    input  logic [PPN_W-1:0]                  req_ppn,
    output logic                              hit,
    output logic [IDX_W-1:0]                  hit_idx,
    output logic                              hit_same
);
    logic [ENTRIES-1:0] ppn_eq;
    logic [ENTRIES-1:0] tag_eq;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign ppn_eq[g] = live_vec[g] && (ppn_tab[g] == req_ppn);
        assign tag_eq[g] = (vpn_tab[g] == req_vpn) && (asid_tab[g] == req_asid);
    end

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (ppn_eq[i]) hit_idx = IDX_W'(i);
        end
    end

    assign hit      = |ppn_eq;
    assign hit_same = |(ppn_eq & tag_eq);

    // No two live slots may ever map one physical page.
    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ppn_eq)); // R3
endmodule

// File: rtl/synfilt_ctrl.sv
module synfilt_ctrl
    import synfilt_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [IDX_W-1:0] req_slot,
    input  logic             hit,
    input  logic [IDX_W-1:0] hit_idx,
    input  logic             hit_same,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [1:0]       rsp_kind,
    output logic [IDX_W-1:0] rsp_idx,
    output logic             wr_en,
    output logic             wr_full,
    output logic [IDX_W-1:0] wr_idx
);
    ctrl_state_e state_q, state_d;
    res_kind_e   kind_d, kind_q;
    logic [IDX_W-1:0] idx_q;
    logic        accept;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_HOLD;
            ST_HOLD: if (rsp_ready) state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_HOLD: rsp_valid = 1'b1;
        endcase
        accept  = req_ready && req_valid;
        if (!hit)          kind_d = RES_ALLOC;
        else if (hit_same) kind_d = RES_PRESENT;
        else               kind_d = RES_REWRITE;
        wr_idx  = hit ? hit_idx : req_slot;
        wr_en   = accept && (kind_d != RES_PRESENT);
        wr_full = (kind_d == RES_ALLOC);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= RES_ALLOC;
            idx_q  <= '0;
        end else if (accept) begin
            kind_q <= kind_d;
            idx_q  <= wr_idx;
        end
    end

    assign rsp_kind = kind_q;
    assign rsp_idx  = idx_q;

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_kind) && $stable(rsp_idx)); // R8
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R8
    AST_ACCEPT_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> rsp_valid); // R8
    AST_ALLOC_AT_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !hit |=> rsp_kind == RES_ALLOC && rsp_idx == $past(req_slot)); // R2
    AST_HIT_AT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && hit |=> rsp_kind != RES_ALLOC && rsp_idx == $past(hit_idx)); // R3
endmodule

// File: rtl/synonym_filter.sv
module synonym_filter #(
    parameter int ENTRIES = 16,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PPN_W   = 16,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [ASID_W-1:0] req_asid,
    input  logic [PPN_W-1:0]  req_ppn,
    input  logic [IDX_W-1:0]  req_slot,
    input  logic              evict_valid,
    input  logic [IDX_W-1:0]  evict_idx,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [1:0]        rsp_kind,
    output logic [IDX_W-1:0]  rsp_idx
);
    logic [ENTRIES-1:0]             live_vec;
    logic [ENTRIES-1:0][VPN_W-1:0]  vpn_tab;
    logic [ENTRIES-1:0][ASID_W-1:0] asid_tab;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppn_tab;
    logic             hit, hit_same;
    logic [IDX_W-1:0] hit_idx;
    logic             wr_en, wr_full;
    logic [IDX_W-1:0] wr_idx;

    synfilt_table #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_table (
        .clk(clk), .rst_n(rst_n),
        .evict_valid(evict_valid), .evict_idx(evict_idx),
        .wr_en(wr_en), .wr_full(wr_full), .wr_idx(wr_idx),
        .wr_vpn(req_vpn), .wr_asid(req_asid), .wr_ppn(req_ppn),
        .live_vec(live_vec), .vpn_tab(vpn_tab), .asid_tab(asid_tab), .ppn_tab(ppn_tab)
    );

    synfilt_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_match (
        .clk(clk), .rst_n(rst_n),
        .live_vec(live_vec), .vpn_tab(vpn_tab), .asid_tab(asid_tab), .ppn_tab(ppn_tab),
        .req_vpn(req_vpn), .req_asid(req_asid), .req_ppn(req_ppn),
        .hit(hit), .hit_idx(hit_idx), .hit_same(hit_same)
    );

    synfilt_ctrl #(.ENTRIES(ENTRIES)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_slot(req_slot),
        .hit(hit), .hit_idx(hit_idx), .hit_same(hit_same),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_kind(rsp_kind), .rsp_idx(rsp_idx),
        .wr_en(wr_en), .wr_full(wr_full), .wr_idx(wr_idx)
    );
endmodule

// File: tb/sim_synonym_filter.sv
module sim_synonym_filter;
    localparam int N = 4;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, rsp_ready = 1'b0, evict_valid = 1'b0;
    logic [7:0] req_vpn = '0;
    logic [3:0] req_asid = '0;
    logic [5:0] req_ppn = '0;
    logic [IW-1:0] req_slot = '0, evict_idx = '0;
    logic req_ready, rsp_valid;
    logic [1:0] rsp_kind;
    logic [IW-1:0] rsp_idx;

    int checks = 0, errors = 0;
    bit fin = 0;

    always #4 clk = ~clk;

    synonym_filter #(.ENTRIES(N), .VPN_W(8), .ASID_W(4), .PPN_W(6)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_asid(req_asid), .req_ppn(req_ppn), .req_slot(req_slot),
        .evict_valid(evict_valid), .evict_idx(evict_idx), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_kind(rsp_kind), .rsp_idx(rsp_idx)
    );

    // Behavioural reference model
    int m_valid[N], m_vpn[N], m_asid[N], m_ppn[N];
    int m_busy = 0, m_kind = 0, m_idx = 0, found;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0;
            for (int i = 0; i < N; i++) m_valid[i] = 0;
        end else begin
            if (evict_valid) m_valid[evict_idx] = 0;
            if (m_busy == 0 && req_valid) begin
                found = -1;
                for (int i = 0; i < N; i++)
                    if (found < 0 && m_valid[i] != 0 && m_ppn[i] == int'(req_ppn)) found = i;
                if (found < 0) begin
                    m_kind = 0; m_idx = req_slot;
                    m_valid[req_slot] = 1; m_vpn[req_slot] = req_vpn;
                    m_asid[req_slot] = req_asid; m_ppn[req_slot] = req_ppn;
                end else if (m_vpn[found] == int'(req_vpn) && m_asid[found] == int'(req_asid)) begin
                    m_kind = 2; m_idx = found;
                end else begin
                    m_kind = 1; m_idx = found;
                    m_vpn[found] = req_vpn; m_asid[found] = req_asid;
                end
                m_busy = 1;
            end else if (m_busy != 0 && rsp_ready) begin
                m_busy = 0;
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !fin) begin
            chk("R8 model req_ready", int'(req_ready), (m_busy == 0) ? 1 : 0);
            chk("R8 model rsp_valid", int'(rsp_valid), m_busy);
            if (m_busy != 0) begin
                chk("R2/R3 model rsp_kind", int'(rsp_kind), m_kind);
                chk("R2/R3 model rsp_idx", int'(rsp_idx), m_idx);
            end
        end
    end

    task automatic do_insert(input int vpn, input int asid, input int ppn, input int slot,
                             input bit ev, input int ev_idx,
                             input int ekind, input int eidx, input string tag);
        @(negedge clk);
        req_vpn = vpn[7:0]; req_asid = asid[3:0]; req_ppn = ppn[5:0]; req_slot = slot[IW-1:0];
        req_valid = 1'b1; rsp_ready = 1'b1;
        evict_valid = ev; evict_idx = ev_idx[IW-1:0];
        @(negedge clk);
        req_valid = 1'b0; evict_valid = 1'b0;
        chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
        chk({tag, " rsp_kind"}, int'(rsp_kind), ekind);
        chk({tag, " rsp_idx"}, int'(rsp_idx), eidx);
    endtask

    task automatic do_evict(input int idx);
        @(negedge clk);
        evict_valid = 1'b1; evict_idx = idx[IW-1:0];
        @(negedge clk);
        evict_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!fin) begin
            fin = 1;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset req_ready", int'(req_ready), 1);
        chk("R1 reset rsp_valid", int'(rsp_valid), 0);

        do_insert(10, 1, 5, 0, 0, 0, 0, 0, "R1 empty table alloc");
        do_insert(11, 1, 6, 1, 0, 0, 0, 1, "R2 alloc victim slot");
        do_insert(20, 1, 5, 3, 0, 0, 1, 0, "R3 synonym rewrite");
        do_insert(20, 1, 5, 2, 0, 0, 2, 0, "R5 identical present");
        do_insert(20, 2, 5, 2, 0, 0, 1, 0, "R4 asid rewrite");
        do_insert(20, 2, 5, 1, 0, 0, 2, 0, "R4 asid stored");
        do_evict(1);
        do_insert(11, 1, 6, 2, 0, 0, 0, 2, "R6 evicted then alloc");
        do_insert(30, 1, 5, 1, 1, 0, 0, 1, "R7 same-cycle evict first");
        do_insert(40, 1, 7, 2, 0, 0, 0, 2, "R2 alloc over live slot");
        do_insert(11, 1, 6, 3, 0, 0, 0, 3, "R2 replaced page gone");

        // Stalled response with a blocked request and an eviction meanwhile
        @(negedge clk);
        req_vpn = 8'd50; req_asid = 4'd1; req_ppn = 6'd9; req_slot = 2'd0;
        req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_vpn = 8'd51; req_ppn = 6'd10; req_slot = 2'd3;
        chk("R8 stall rsp_kind", int'(rsp_kind), 0);
        chk("R8 stall rsp_idx", int'(rsp_idx), 0);
        evict_valid = 1'b1; evict_idx = 2'd0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            evict_valid = 1'b0;
            chk("R8 stall rsp_valid held", int'(rsp_valid), 1);
            chk("R8 stall req_ready low", int'(req_ready), 0);
            chk("R8 stall idx stable", int'(rsp_idx), 0);
        end
        req_valid = 1'b0; rsp_ready = 1'b1;
        @(negedge clk);
        chk("R8 released", int'(rsp_valid), 0);
        do_insert(50, 1, 9, 1, 0, 0, 0, 1, "R9 evict during stall");
        do_insert(51, 1, 10, 3, 0, 0, 0, 3, "R8 blocked request ignored");

        // Random phase against the model
        for (int c = 0; c < 600; c++) begin
            @(negedge clk);
            req_valid   = ($urandom_range(0, 1) == 1);
            req_vpn     = 8'($urandom_range(0, 2));
            req_asid    = 4'($urandom_range(0, 1));
            req_ppn     = 6'($urandom_range(0, 5));
            req_slot    = IW'($urandom_range(0, N - 1));
            rsp_ready   = ($urandom_range(0, 3) != 0);
            evict_valid = ($urandom_range(0, 3) == 0);
            evict_idx   = IW'($urandom_range(0, N - 1));
        end
        @(negedge clk);
        req_valid = 1'b0; evict_valid = 1'b0; rsp_ready = 1'b1;
        repeat (3) @(negedge clk);
        fin = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule